// File: doc/BRIEF.md
# Register-Offset Halfword and Byte Load/Store Unit

This unit executes one family of 16-bit compressed instructions. Every member forms its address by adding two registers. The family has one halfword store and three loads: an unsigned halfword load, a signed byte load and a signed halfword load. An instruction word arrives with a one-cycle valid strobe while the unit is idle. The unit reads the base, offset and data registers from an eight-entry, 32-bit register file that it owns. It then places a single request on a word-wide little-endian memory port that carries byte enables and a ready/valid handshake.

A load waits for the response, shifts the addressed lane down, extends it to 32 bits and writes it into the destination register in the cycle the response arrives. A store writes the register's low halfword and changes no register. An instruction word that is not part of this family raises a one-cycle "foreign" flag and is otherwise dropped. A halfword access at an odd address raises a one-cycle "misaligned" flag and causes no memory traffic and no register write.

A test port lets the surrounding environment preload and inspect registers directly. A bench uses it to compare the register file against a reference model.

Top module: `regoff_lsu`

## Requirements
- R1: An instruction is accepted as part of the family only when bits [15:12] equal 4'b0101 and bit 9 is 1. For any other word presented while idle, foreign_o is high for exactly one cycle starting one cycle after the strobe, with no memory request and no register change.
- R2: Field positions: data register in bits [2:0], base register in [5:3], offset register in [8:6], halfword flag H in bit 11, sign flag S in bit 10.
- R3: The memory address is the 32-bit sum of the base and offset register values, wrapping modulo 2^32.
- R4: With S=0 and H=0, the unit writes with mem_we_o=1. mem_be_o is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. mem_wdata_o carries the data register's bits [15:0] in both halfword lanes. No register is written.
- R5: With S=0 and H=1, the unit reads with the same byte enables as R4. The destination receives the addressed halfword in bits [15:0], with bits [31:16] cleared.
- R6: With S=1 and H=0, the unit reads with mem_be_o = 1 << address[1:0]. The destination receives the byte from bits [8*address[1:0]+7 : 8*address[1:0]], with bits [31:8] set to its bit 7.
- R7: With S=1 and H=1, the unit reads with the byte enables of R4. The destination receives the addressed halfword, with bits [31:16] set to its bit 15.
- R8: A halfword store or load whose address has bit 0 set pulses misaligned_o for one cycle, starting one cycle after the strobe. It issues no memory request and writes no register.
- R9: While mem_req_o is high and mem_ready_i is low, the request stays asserted and address, enables, write data and direction hold steady.
- R10: Each executed instruction produces exactly one memory handshake and one done_o pulse of a single cycle. A store's pulse follows the cycle its request is accepted. A load's pulse follows the cycle mem_rvalid_i is seen, and the destination register holds the result by the time done_o is high.
- R11: While busy_o is high, instr_valid_i is ignored: no extra request, no flag, no register change.
- R12: After reset all registers read zero. While idle, tp_we_i writes tp_wdata_i into register tp_addr_i at the clock edge, and tp_rdata_o shows register tp_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| instr_valid_i | input | 1 | Instruction strobe, sampled while idle |
| instr_i | input | 16 | Instruction word |
| busy_o | output | 1 | An accepted instruction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| foreign_o | output | 1 | One-cycle pulse: word outside this family |
| misaligned_o | output | 1 | One-cycle pulse: odd halfword address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_be_o | output | 4 | Byte enables, bit n = byte lane n |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| tp_we_i | input | 1 | Test port register write |
| tp_addr_i | input | 3 | Test port register index |
| tp_wdata_i | input | 32 | Test port write data |
| tp_rdata_o | output | 32 | Test port read data |

## Verification
Assertions check several rules on every cycle. A pending request holds steady. Done, foreign and misaligned never overlap with a request in a way that breaks the handshake. Byte-enable shapes fit each operation. Every writeback has the right upper-bit extension for its operation, and a busy unit ignores the strobe. Other behaviours show only in the bench's scenarios against its model: the exact address sum with wraparound, the lane chosen and its data, the register that receives a load, and the fact that stores and rejected words leave memory and registers untouched. The scenarios cover random operand values, odd and even addresses, negative bytes and halfwords, and memory stalls.

// File: rtl/regoff_lsu_pkg.sv
package regoff_lsu_pkg;

  localparam int REG_IDX_W = 3;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int INSTR_W   = 16;

  // Operation code is {S, H}, taken from instruction bits 10 and 11.
  typedef enum logic [1:0] {
    OP_STH  = 2'b00,
    OP_LDH  = 2'b01,
    OP_LDSB = 2'b10,
    OP_LDSH = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_RESP = 2'b10
  } st_e;

  typedef struct packed {
    logic                 hit;
    op_e                  op;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rb;
    logic [REG_IDX_W-1:0] ro;
  } dec_t;

endpackage

// File: rtl/regoff_decode.sv
module regoff_decode
  import regoff_lsu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  always_comb begin
    dec_o.hit = (instr_i[15:12] == 4'b0101) && instr_i[9];
    dec_o.op  = op_e'({instr_i[10], instr_i[11]});
    dec_o.rd  = instr_i[2:0];
    dec_o.rb  = instr_i[5:3];
    dec_o.ro  = instr_i[8:6];
  end

endmodule

// File: rtl/regoff_regfile.sv
module regoff_regfile #(
  parameter  int DATA_W = 32,
  parameter  int NREG   = 8,
  localparam int AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic [AW-1:0]     raddr_s_i,
  output logic [15:0]       rdata_s_o,
  input  logic [AW-1:0]     raddr_t_i,
  output logic [DATA_W-1:0] rdata_t_o
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    logic              wen;
    assign wen = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wen) begin
        q <= wdata_i;
      end
    end
    assign regs[g] = q;
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign rdata_s_o = regs[raddr_s_i][15:0];
  assign rdata_t_o = regs[raddr_t_i];

endmodule

// File: rtl/regoff_req_lane.sv
module regoff_req_lane
  import regoff_lsu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LW     = $clog2(NB)
) (
  input  op_e               op_i,
  input  logic [LW-1:0]     lo_i,
  input  logic [15:0]       src_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misaligned_o
);

  localparam int NH = NB / 2;

  always_comb begin
    if (op_i == OP_LDSB) begin
      be_o = NB'(1) << lo_i;
    end else begin
      be_o = NB'(3) << {lo_i[LW-1:1], 1'b0};
    end
  end

  assign misaligned_o = (op_i != OP_LDSB) && lo_i[0];

  for (genvar g = 0; g < NH; g++) begin : g_rep
    assign wdata_o[16*g +: 16] = src_i;
  end

endmodule

// File: rtl/regoff_load_ext.sv
module regoff_load_ext
  import regoff_lsu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LW     = $clog2(NB)
) (
  input  op_e               op_i,
  input  logic [LW-1:0]     lo_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ext_o
);

  logic [7:0]  byte_v;
  logic [15:0] half_v;

  assign byte_v = rdata_i[{lo_i, 3'b000} +: 8];
  assign half_v = rdata_i[{lo_i[LW-1:1], 4'b0000} +: 16];

  always_comb begin
    case (op_i)
      OP_LDSB: ext_o = {{(DATA_W-8){byte_v[7]}}, byte_v};
      OP_LDSH: ext_o = {{(DATA_W-16){half_v[15]}}, half_v};
      default: ext_o = {{(DATA_W-16){1'b0}}, half_v};
    endcase
  end

endmodule

// File: rtl/regoff_lsu.sv
module regoff_lsu
  import regoff_lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_valid_i,
  input  logic [INSTR_W-1:0]    instr_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  foreign_o,
  output logic                  misaligned_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [DATA_W-1:0]     mem_addr_o,
  output logic [DATA_W/8-1:0]   mem_be_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic                  mem_ready_i,
  input  logic                  mem_rvalid_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  input  logic                  tp_we_i,
  input  logic [REG_IDX_W-1:0]  tp_addr_i,
  input  logic [DATA_W-1:0]     tp_wdata_i,
  output logic [DATA_W-1:0]     tp_rdata_o
);

  localparam int NB = DATA_W / 8;
  localparam int LW = $clog2(NB);

  dec_t                 dec;
  logic [DATA_W-1:0]    base_val;
  logic [DATA_W-1:0]    off_val;
  logic [15:0]          src_val;
  logic [DATA_W-1:0]    addr_now;
  logic [NB-1:0]        be_now;
  logic [DATA_W-1:0]    wdata_now;
  logic                 mis_now;
  logic [DATA_W-1:0]    wb_data;

  st_e                  state_q, state_d;
  logic [DATA_W-1:0]    addr_q;
  logic [NB-1:0]        be_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 we_q;
  op_e                  op_q;
  logic [REG_IDX_W-1:0] rd_q;
  logic                 done_q, done_d;
  logic                 foreign_q, foreign_d;
  logic                 mis_q, mis_d;

  logic                 accept;
  logic                 launch;
  logic                 wb_en;
  logic                 rf_we;
  logic [REG_IDX_W-1:0] rf_waddr;
  logic [DATA_W-1:0]    rf_wdata;

  regoff_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  regoff_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NUM_REGS)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (dec.rb),
    .rdata_a_o (base_val),
    .raddr_b_i (dec.ro),
    .rdata_b_o (off_val),
    .raddr_s_i (dec.rd),
    .rdata_s_o (src_val),
    .raddr_t_i (tp_addr_i),
    .rdata_t_o (tp_rdata_o)
  );

  assign addr_now = base_val + off_val;

  regoff_req_lane #(
    .DATA_W (DATA_W)
  ) u_req (
    .op_i         (dec.op),
    .lo_i         (addr_now[LW-1:0]),
    .src_i        (src_val),
    .be_o         (be_now),
    .wdata_o      (wdata_now),
    .misaligned_o (mis_now)
  );

  regoff_load_ext #(
    .DATA_W (DATA_W)
  ) u_ext (
    .op_i    (op_q),
    .lo_i    (addr_q[LW-1:0]),
    .rdata_i (mem_rdata_i),
    .ext_o   (wb_data)
  );

  // Control: next-state and pulse decisions
  always_comb begin
    accept    = instr_valid_i && (state_q == ST_IDLE);
    launch    = accept && dec.hit && !mis_now;
    foreign_d = accept && !dec.hit;
    mis_d     = accept && dec.hit && mis_now;
    wb_en     = (state_q == ST_RESP) && mem_rvalid_i;
    done_d    = ((state_q == ST_REQ) && mem_ready_i && we_q) || wb_en;
    state_d   = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_REQ;
      ST_REQ:  if (mem_ready_i) state_d = we_q ? ST_IDLE : ST_RESP;
      ST_RESP: if (mem_rvalid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      foreign_q <= 1'b0;
      mis_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= done_d;
      foreign_q <= foreign_d;
      mis_q     <= mis_d;
    end
  end

  // Request capture, enabled only when an instruction is launched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      op_q    <= OP_STH;
      rd_q    <= '0;
    end else if (launch) begin
      addr_q  <= addr_now;
      be_q    <= be_now;
      wdata_q <= wdata_now;
      we_q    <= (dec.op == OP_STH);
      op_q    <= dec.op;
      rd_q    <= dec.rd;
    end
  end

  // Register file write: load writeback wins over the test port
  always_comb begin
    rf_we    = wb_en || tp_we_i;
    rf_waddr = wb_en ? rd_q : tp_addr_i;
    rf_wdata = wb_en ? wb_data : tp_wdata_i;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign foreign_o    = foreign_q;
  assign misaligned_o = mis_q;
  assign mem_req_o    = (state_q == ST_REQ);
  assign mem_we_o     = we_q;
  assign mem_addr_o   = addr_q;
  assign mem_be_o     = be_q;
  assign mem_wdata_o  = wdata_q;

  // Assertions

  p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_o |-> (!mem_req_o && !done_o && !misaligned_o));

  p_store_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !we_q);

  p_half_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && op_q != OP_LDSB) |-> (($countones(mem_be_o) == 2) && !mem_addr_o[0]));

  p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && op_q == OP_LDH) |-> (wb_data[DATA_W-1:16] == '0));

  p_byte_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && op_q == OP_LDSB) |-> ($countones(mem_be_o) == 1));

  p_byte_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && op_q == OP_LDSB) |->
      ((wb_data[DATA_W-1:7] == '0) || (&wb_data[DATA_W-1:7])));

  p_half_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && op_q == OP_LDSH) |->
      ((wb_data[DATA_W-1:15] == '0) || (&wb_data[DATA_W-1:15])));

  p_mis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned_o |-> (!mem_req_o && !done_o));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o) &&
       $stable(mem_wdata_o) && $stable(mem_we_o)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && instr_valid_i) |=> (!foreign_o && !misaligned_o));

endmodule

// File: tb/test_regoff_lsu.sv
module test_regoff_lsu;

  logic        clk;
  logic        rst_n;
  logic        instr_valid_i;
  logic [15:0] instr_i;
  logic        busy_o, done_o, foreign_o, misaligned_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i, mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        tp_we_i;
  logic [2:0]  tp_addr_i;
  logic [31:0] tp_wdata_i, tp_rdata_o;

  int checks = 0;
  int bad    = 0;

  logic [31:0] rf_m  [8];
  logic [31:0] mem_d [64];
  logic [31:0] mem_m [64];

  int          stall    = 0;
  bit          rsp_pend = 0;
  int          rsp_wait = 0;
  logic [5:0]  rsp_idx  = '0;
  int          acc_cnt  = 0;
  logic [31:0] acc_addr, acc_wdata;
  logic [3:0]  acc_be;
  logic        acc_we;

  regoff_lsu i_regoff_lsu (
    .clk (clk), .rst_n (rst_n),
    .instr_valid_i (instr_valid_i), .instr_i (instr_i),
    .busy_o (busy_o), .done_o (done_o), .foreign_o (foreign_o),
    .misaligned_o (misaligned_o),
    .mem_req_o (mem_req_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
    .mem_be_o (mem_be_o), .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i), .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .tp_we_i (tp_we_i), .tp_addr_i (tp_addr_i), .tp_wdata_i (tp_wdata_i),
    .tp_rdata_o (tp_rdata_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic s, input logic h,
      input logic [2:0] ro, input logic [2:0] rb, input logic [2:0] rd);
    return {4'b0101, h, s, 1'b1, ro, rb, rd};
  endfunction

  function automatic logic [31:0] f_ext(input logic [31:0] w, input logic s,
                                        input logic h, input logic [1:0] lo);
    logic [7:0]  b;
    logic [15:0] hw;
    b  = w[8*lo +: 8];
    hw = lo[1] ? w[31:16] : w[15:0];
    if (s && !h) return {{24{b[7]}}, b};
    if (s && h)  return {{16{hw[15]}}, hw};
    return {16'h0000, hw};
  endfunction

  // Behavioural memory, driven away from the active edge
  initial begin
    mem_ready_i  = 1'b0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    forever begin
      @(negedge clk);
      mem_ready_i  = 1'b0;
      mem_rvalid_i = 1'b0;
      if (rsp_pend) begin
        if (rsp_wait == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_d[rsp_idx];
          rsp_pend     = 0;
        end else begin
          rsp_wait--;
        end
      end else if (mem_req_o) begin
        if (stall > 0) begin
          stall--;
        end else if ($urandom % 3 != 0) begin
          mem_ready_i = 1'b1;
          acc_cnt++;
          acc_addr  = mem_addr_o;
          acc_be    = mem_be_o;
          acc_we    = mem_we_o;
          acc_wdata = mem_wdata_o;
          if (mem_we_o) begin
            for (int b = 0; b < 4; b++)
              if (mem_be_o[b]) mem_d[mem_addr_o[7:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
          end else begin
            rsp_pend = 1;
            rsp_wait = $urandom % 3;
            rsp_idx  = mem_addr_o[7:2];
          end
        end
      end
    end
  end

  task automatic wr_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    tp_we_i    = 1'b1;
    tp_addr_i  = 3'(i);
    tp_wdata_i = v;
    rf_m[i]    = v;
    @(negedge clk);
    tp_we_i    = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tp_addr_i = 3'(i);
      #1;
      chk(tag, $sformatf("reg%0d via test port", i), tp_rdata_o, rf_m[i]);
    end
  endtask

  task automatic run_one(input logic [15:0] ins, input bit probe);
    logic        legal, s, h, mis, exec;
    logic [2:0]  rd, rb, ro;
    logic [31:0] a;
    logic [3:0]  exp_be;
    bit          got_d, got_f, got_m;
    int          c0;
    string       tag;
    legal = (ins[15:12] == 4'b0101) && ins[9];
    s  = ins[10];
    h  = ins[11];
    rd = ins[2:0];
    rb = ins[5:3];
    ro = ins[8:6];
    a  = rf_m[rb] + rf_m[ro];
    mis  = legal && !(s && !h) && a[0];
    exec = legal && !mis;
    if (!legal) tag = "R1";
    else if (mis) tag = "R8";
    else if (!s && !h) tag = "R4";
    else if (!s && h) tag = "R5";
    else if (s && !h) tag = "R6";
    else tag = "R7";
    exp_be = (s && !h) ? (4'b0001 << a[1:0]) : (a[1] ? 4'b1100 : 4'b0011);
    c0 = acc_cnt;
    got_d = 0; got_f = 0; got_m = 0;
    if (probe) stall = 4;
    @(negedge clk);
    instr_i = ins;
    instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
    instr_i = 16'($urandom);
    for (int k = 0; k < 200; k++) begin
      if (k == 1) instr_valid_i = 1'b0;
      if (k == 0 && probe) begin
        instr_valid_i = 1'b1;
        instr_i = mk(1'b0, 1'b0, 3'd1, 3'd2, 3'd3);
      end
      if (done_o || foreign_o || misaligned_o) begin
        got_d = done_o; got_f = foreign_o; got_m = misaligned_o;
        break;
      end
      @(negedge clk);
    end
    instr_valid_i = 1'b0;
    chk(tag, "done flag", 32'(got_d), 32'(exec));
    chk("R1", "foreign flag", 32'(got_f), 32'(!legal));
    chk("R8", "misaligned flag", 32'(got_m), 32'(mis));
    @(negedge clk);
    chk("R10", "pulses one cycle wide", {29'd0, done_o, foreign_o, misaligned_o}, 32'd0);
    chk(probe ? "R11" : "R10", "handshake count", 32'(acc_cnt - c0), 32'(exec));
    if (exec) begin
      chk("R3", "address", acc_addr, a);
      chk(tag, "byte enables", {28'd0, acc_be}, {28'd0, exp_be});
      chk(tag, "write direction", 32'(acc_we), 32'(!s && !h));
      if (!s && !h) begin
        chk("R4", "store data", acc_wdata, {rf_m[rd][15:0], rf_m[rd][15:0]});
        for (int b = 0; b < 4; b++)
          if (exp_be[b]) mem_m[a[7:2]][8*b +: 8] = rf_m[rd][15:0] >> (8*(b%2));
        chk("R4", "memory word", mem_d[a[7:2]], mem_m[a[7:2]]);
      end else begin
        rf_m[rd] = f_ext(mem_m[a[7:2]], s, h, a[1:0]);
      end
    end
    check_regs(probe ? "R11" : tag);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    instr_valid_i = 1'b0;
    instr_i = '0;
    tp_we_i = 1'b0;
    tp_addr_i = '0;
    tp_wdata_i = '0;
    for (int i = 0; i < 64; i++) begin
      mem_d[i] = $urandom;
      mem_m[i] = mem_d[i];
    end
    for (int i = 0; i < 8; i++) rf_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "busy after reset", 32'(busy_o), 32'd0);
    chk("R10", "done after reset", 32'(done_o), 32'd0);
    chk("R9", "request after reset", 32'(mem_req_o), 32'd0);
    check_regs("R12");

    // Directed: negative byte in lane 3 (R6, R2)
    mem_d[4] = 32'h8011_2233;
    mem_m[4] = mem_d[4];
    wr_reg(2, 32'h0000_0010);
    wr_reg(5, 32'h0000_0003);
    run_one(mk(1'b1, 1'b0, 3'd5, 3'd2, 3'd0), 0);
    chk("R6", "negative byte lane 3", rf_m[0], 32'hFFFF_FF80);
    // Halfword upper lane, signed and unsigned (R7, R5)
    wr_reg(5, 32'h0000_0002);
    run_one(mk(1'b1, 1'b1, 3'd5, 3'd2, 3'd1), 0);
    chk("R7", "negative halfword", rf_m[1], 32'hFFFF_8011);
    run_one(mk(1'b0, 1'b1, 3'd5, 3'd2, 3'd7), 0);
    chk("R5", "zero-extended halfword", rf_m[7], 32'h0000_8011);
    // Store into upper lane (R4)
    wr_reg(3, 32'hABCD_1234);
    wr_reg(5, 32'h0000_000E);
    run_one(mk(1'b0, 1'b0, 3'd5, 3'd2, 3'd3), 0);
    // Misaligned halfword load and store (R8)
    wr_reg(5, 32'h0000_0001);
    run_one(mk(1'b0, 1'b1, 3'd5, 3'd2, 3'd6), 0);
    run_one(mk(1'b0, 1'b0, 3'd5, 3'd2, 3'd3), 0);
    // Odd address byte load is fine (R6)
    run_one(mk(1'b1, 1'b0, 3'd5, 3'd2, 3'd4), 0);
    // Foreign words (R1)
    run_one(16'h5000 | 16'h0C00 | 16'h0011, 0);
    run_one(16'h0000, 0);
    run_one(16'h7200, 0);
    // Address wraparound (R3)
    wr_reg(2, 32'hFFFF_FFFC);
    wr_reg(5, 32'h0000_0008);
    run_one(mk(1'b1, 1'b1, 3'd5, 3'd2, 3'd6), 0);
    // Strobe while busy is ignored (R11), stalled request holds (R9)
    wr_reg(5, 32'h0000_0020);
    run_one(mk(1'b0, 1'b1, 3'd5, 3'd2, 3'd4), 1);

    // Random mix
    for (int n = 0; n < 250; n++) begin
      logic [15:0] ins;
      for (int i = 0; i < 8; i++) wr_reg(i, $urandom);
      if ($urandom % 10 == 0) ins = 16'($urandom);
      else ins = mk(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
      run_one(ins, (n % 50) == 7);
    end

    summary();
    $finish;
  end

endmodule